// File: doc/BRIEF.md
# Double-Data-Rate Burst Column Sequencer

This block produces the column address order for one double-data-rate burst. A start pulse, given with a READ or WRITE, carries the starting column, a burst-length code and an ordering select. Two data beats move per clock, so the block emits two column addresses each cycle: one for the even beat and one for the odd beat. A burst of BL beats therefore lasts BL/2 cycles. A flag marks the final pair.

Only the low log2(BL) column bits move during a burst. The higher bits are held from the start column. In sequential order the offset counts upward and wraps inside the burst-aligned block. In interleaved order each beat offset is the start offset XORed with the beat number. If a new start arrives before the current burst ends, the current burst stops and the new one begins at once.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `valid_o` and `last_o` are 0 and both address outputs are 0.
- R2: A `start_i` sampled at a rising edge makes pair 0 of the new burst appear on the outputs right after that same edge, with `valid_o` = 1.
- R3: `blen_i` encodes the burst length: 0 gives 2 beats, 1 gives 4, 2 gives 8 and 3 gives 16. With no further start, `valid_o` stays high for exactly BL/2 consecutive cycles.
- R4: `last_o` is 1 only on the final pair (pair BL/2-1) of a burst that is not interrupted.
- R5: With `ilv_i` = 0, beat k carries the low offset (start offset + k) mod BL. For example, 16 beats from offset 0xB run B,C,D,E,F,0,1,...,A.
- R6: With `ilv_i` = 1, beat k carries the offset (start offset XOR k). For example, 4 beats from 1 run 1,0,3,2, and 8 beats from 2 run 2,3,0,1,6,7,4,5.
- R7: Column bits at and above position log2(BL) equal those of the start column on every beat of the burst.
- R8: A `start_i` during an active burst ends that burst without asserting `last_o`. The new burst's pair 0 appears in the next cycle.
- R9: When `valid_o` is 0, both address outputs and `last_o` are 0.
- R10: In pair p, `even_col_o` carries beat 2p and `odd_col_o` carries beat 2p+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Starts a burst (READ or WRITE accepted) |
| start_col_i | input | COL_W | Starting column address |
| blen_i | input | 2 | Burst length code (0:2, 1:4, 2:8, 3:16) |
| ilv_i | input | 1 | 1 selects interleaved order, 0 selects sequential |
| even_col_o | output | COL_W | Column for the even beat of the current pair |
| odd_col_o | output | COL_W | Column for the odd beat of the current pair |
| valid_o | output | 1 | A pair is presented this cycle |
| last_o | output | 1 | The presented pair ends the burst |

## Verification
A wrong pair counter shows up as a burst that is too short or too long, or as `last_o` on the wrong cycle. Both are visible within BL/2 cycles of the start. A wrong latched offset or mode shows on the very first pair: the even and odd columns break the expected order, or the high column bits drift from the start column. A truncation fault shows one cycle after the interrupting start, when pair 0 of the new burst fails to appear.

// File: rtl/bas_pkg.sv
package bas_pkg;
  localparam int OFF_W  = 4;
  localparam int PAIR_W = OFF_W - 1;

  typedef enum logic [1:0] {BLC_2 = 2'd0, BLC_4 = 2'd1, BLC_8 = 2'd2, BLC_16 = 2'd3} bl_code_t;

  // Mask of the column bits that move for a burst length code.
  function automatic logic [OFF_W-1:0] low_mask(input bl_code_t c);
    logic [OFF_W:0] one_hot;
    one_hot  = (OFF_W+1)'(2) << c;
    low_mask = OFF_W'(one_hot - 1'b1);
  endfunction

  // Index of the final pair for a burst length code.
  function automatic logic [PAIR_W-1:0] final_pair(input bl_code_t c);
    logic [OFF_W-1:0] m;
    m          = low_mask(c);
    final_pair = m[OFF_W-1:1];
  endfunction
endpackage

// File: rtl/bas_ctrl.sv
module bas_ctrl
  import bas_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic [COL_W-1:0]    start_col_i,
  input  bl_code_t            blen_i,
  input  logic                ilv_i,
  output logic                nx_act_o,
  output logic [PAIR_W-1:0]   nx_pair_o,
  output logic [COL_W-1:0]    nx_col_o,
  output bl_code_t            nx_blen_o,
  output logic                nx_ilv_o,
  output logic                nx_last_o
);
  logic              act_q;
  logic [PAIR_W-1:0] pair_q;
  logic [COL_W-1:0]  col_q;
  bl_code_t          blen_q;
  logic              ilv_q;

  always_comb begin
    nx_act_o  = act_q;
    nx_pair_o = pair_q;
    nx_col_o  = col_q;
    nx_blen_o = blen_q;
    nx_ilv_o  = ilv_q;
    if (start_i) begin
      nx_act_o  = 1'b1;
      nx_pair_o = '0;
      nx_col_o  = start_col_i;
      nx_blen_o = blen_i;
      nx_ilv_o  = ilv_i;
    end else if (act_q) begin
      if (pair_q == final_pair(blen_q)) begin
        nx_act_o  = 1'b0;
        nx_pair_o = '0;
      end else begin
        nx_pair_o = pair_q + 1'b1;
      end
    end
    nx_last_o = nx_act_o && (nx_pair_o == final_pair(nx_blen_o));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      pair_q <= '0;
      col_q  <= '0;
      blen_q <= BLC_2;
      ilv_q  <= 1'b0;
    end else begin
      act_q  <= nx_act_o;
      pair_q <= nx_pair_o;
      col_q  <= nx_col_o;
      blen_q <= nx_blen_o;
      ilv_q  <= nx_ilv_o;
    end
  end
endmodule

// File: rtl/bas_beat_gen.sv
module bas_beat_gen
  import bas_pkg::*;
#(
  parameter int COL_W = 10,
  parameter int LANE  = 0
) (
  input  logic [COL_W-1:0]  col_i,
  input  bl_code_t          blen_i,
  input  logic              ilv_i,
  input  logic [PAIR_W-1:0] pair_i,
  output logic [COL_W-1:0]  addr_o
);
  logic [OFF_W-1:0] mask, off, beat, low;
  logic [COL_W-1:0] wide_mask;

  always_comb begin
    mask      = low_mask(blen_i);
    off       = col_i[OFF_W-1:0] & mask;
    beat      = {pair_i, 1'(LANE)};
    low       = (ilv_i ? (off ^ beat) : (off + beat)) & mask;
    wide_mask = {{(COL_W-OFF_W){1'b0}}, mask};
    addr_o    = (col_i & ~wide_mask) | {{(COL_W-OFF_W){1'b0}}, low};
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bas_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [1:0]       blen_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] even_col_o,
  output logic [COL_W-1:0] odd_col_o,
  output logic             valid_o,
  output logic             last_o
);
  localparam int LANES = 2;

  logic              nx_act, nx_ilv, nx_last;
  logic [PAIR_W-1:0] nx_pair;
  logic [COL_W-1:0]  nx_col;
  bl_code_t          nx_blen;
  logic [COL_W-1:0]  lane_addr [LANES];

  bas_ctrl #(.COL_W(COL_W)) ctrl_i (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .blen_i      (bl_code_t'(blen_i)),
    .ilv_i       (ilv_i),
    .nx_act_o    (nx_act),
    .nx_pair_o   (nx_pair),
    .nx_col_o    (nx_col),
    .nx_blen_o   (nx_blen),
    .nx_ilv_o    (nx_ilv),
    .nx_last_o   (nx_last)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    bas_beat_gen #(.COL_W(COL_W), .LANE(g)) gen_i (
      .col_i  (nx_col),
      .blen_i (nx_blen),
      .ilv_i  (nx_ilv),
      .pair_i (nx_pair),
      .addr_o (lane_addr[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o    <= 1'b0;
      last_o     <= 1'b0;
      even_col_o <= '0;
      odd_col_o  <= '0;
    end else begin
      valid_o    <= nx_act;
      last_o     <= nx_last;
      even_col_o <= nx_act ? lane_addr[0] : '0;
      odd_col_o  <= nx_act ? lane_addr[1] : '0;
    end
  end
endmodule

// File: rtl/bas_checker.sv
module bas_checker #(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic [COL_W-1:0] even_col_o,
  input logic [COL_W-1:0] odd_col_o,
  input logic             valid_o,
  input logic             last_o
);
  p_start_valid_r2: assert property (@(posedge clk) disable iff (rst)
    start_i |=> valid_o);

  p_last_valid_r4: assert property (@(posedge clk) disable iff (rst)
    last_o |-> valid_o);

  p_end_after_last_r3: assert property (@(posedge clk) disable iff (rst)
    (last_o && !start_i) |=> !valid_o);

  p_idle_zero_r9: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> (even_col_o == '0 && odd_col_o == '0 && !last_o));

  p_pair_adjacent_r10: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !even_col_o[0]) |-> (odd_col_o == (even_col_o | COL_W'(1))));

  p_upper_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !start_i) |=> (!valid_o ||
      even_col_o[COL_W-1:4] == $past(even_col_o[COL_W-1:4])));
endmodule

bind burst_addr_seq bas_checker #(.COL_W(COL_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .start_i    (start_i),
  .even_col_o (even_col_o),
  .odd_col_o  (odd_col_o),
  .valid_o    (valid_o),
  .last_o     (last_o)
);

// File: tb/burst_addr_seq_tb_top.sv
module burst_addr_seq_tb_top;
  localparam int COL_W = 10;

  typedef struct {
    logic             valid;
    logic             last;
    logic [COL_W-1:0] even;
    logic [COL_W-1:0] odd;
    string            req;
  } item_t;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start_i = 1'b0;
  logic [COL_W-1:0] start_col_i = '0;
  logic [1:0]       blen_i = '0;
  logic             ilv_i = 1'b0;
  logic [COL_W-1:0] even_col_o, odd_col_o;
  logic             valid_o, last_o;

  int    total = 0;
  int    bad = 0;
  item_t exp_q[$];
  bit    done = 1'b0;

  always #2.5 clk = ~clk;

  burst_addr_seq #(.COL_W(COL_W)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .start_col_i(start_col_i),
    .blen_i(blen_i), .ilv_i(ilv_i), .even_col_o(even_col_o),
    .odd_col_o(odd_col_o), .valid_o(valid_o), .last_o(last_o)
  );

  function automatic logic [COL_W-1:0] beat_col(input logic [COL_W-1:0] col,
      input int blc, input bit ilv, input int k);
    int bl, off, low;
    bl  = 2 << blc;
    off = int'(col) % bl;
    low = ilv ? ((off ^ k) % bl) : ((off + k) % bl);
    return COL_W'((int'(col) / bl) * bl + low);
  endfunction

  task automatic push_idle(input string req);
    item_t it;
    it.valid = 1'b0; it.last = 1'b0; it.even = '0; it.odd = '0; it.req = req;
    exp_q.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      start_i = 1'b0;
      push_idle("R9");
    end
  endtask

  // Drives a burst; run < full pairs leaves it to be cut by the next start.
  task automatic burst(input logic [COL_W-1:0] col, input int blc, input bit ilv,
      input int run, input string req);
    int full;
    full = (2 << blc) / 2;
    for (int p = 0; p < run; p++) begin
      item_t it;
      @(negedge clk);
      start_i = (p == 0);
      start_col_i = col; blen_i = 2'(blc); ilv_i = ilv;
      it.valid = 1'b1;
      it.last  = (p == full - 1);
      it.even  = beat_col(col, blc, ilv, 2 * p);
      it.odd   = beat_col(col, blc, ilv, 2 * p + 1);
      it.req   = req;
      exp_q.push_back(it);
    end
  endtask

  // Literal order from the requirement text: offsets listed beat by beat.
  task automatic burst_lit(input logic [COL_W-1:0] col, input int blc, input bit ilv,
      input logic [3:0] offs [16], input string req);
    int full;
    full = (2 << blc) / 2;
    for (int p = 0; p < full; p++) begin
      item_t it;
      @(negedge clk);
      start_i = (p == 0);
      start_col_i = col; blen_i = 2'(blc); ilv_i = ilv;
      it.valid = 1'b1;
      it.last  = (p == full - 1);
      it.even  = {col[COL_W-1:4], offs[2*p]};
      it.odd   = {col[COL_W-1:4], offs[2*p+1]};
      it.req   = req;
      exp_q.push_back(it);
    end
  endtask

  // Scoreboard monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        item_t e;
        e = exp_q.pop_front();
        total++;
        if (valid_o !== e.valid || last_o !== e.last ||
            even_col_o !== e.even || odd_col_o !== e.odd) begin
          bad++;
          $display("FAIL %s: got v=%0b l=%0b e=%h o=%h exp v=%0b l=%0b e=%h o=%h",
                   e.req, valid_o, last_o, even_col_o, odd_col_o,
                   e.valid, e.last, e.even, e.odd);
        end
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [3:0] s16 [16];
    logic [3:0] i4 [16];
    logic [3:0] i8 [16];
    for (int i = 0; i < 16; i++) begin
      s16[i] = 4'((11 + i) % 16);
      i4[i] = '0; i8[i] = '0;
    end
    i4[0] = 1; i4[1] = 0; i4[2] = 3; i4[3] = 2;
    i8[0] = 2; i8[1] = 3; i8[2] = 0; i8[3] = 1;
    i8[4] = 6; i8[5] = 7; i8[6] = 4; i8[7] = 5;

    repeat (3) @(posedge clk);
    #1;
    total++; // R1 during reset
    if (valid_o !== 1'b0 || last_o !== 1'b0 || even_col_o !== '0 || odd_col_o !== '0) begin
      bad++;
      $display("FAIL R1: got v=%0b l=%0b e=%h o=%h exp all zero",
               valid_o, last_o, even_col_o, odd_col_o);
    end
    @(negedge clk);
    rst = 1'b0;
    push_idle("R1");
    idle(2);

    // R5 literal, R6 literals
    burst_lit(10'h2AB, 3, 1'b0, s16, "R5");
    idle(2);
    burst_lit(10'h151, 1, 1'b1, i4, "R6");
    idle(1);
    burst_lit(10'h0C2, 2, 1'b1, i8, "R6");
    idle(1);

    // R3 all length codes, both orders; R4 last; R7 upper bits; R10 lanes
    for (int b = 0; b < 4; b++) begin
      burst(10'h3A5, b, 1'b0, (2 << b) / 2, "R3");
      idle(1);
      burst(10'h25E, b, 1'b1, (2 << b) / 2, "R7");
      idle(1);
    end

    // R2 back-to-back bursts
    burst(10'h013, 1, 1'b0, 2, "R2");
    burst(10'h107, 0, 1'b1, 1, "R10");
    burst(10'h3FF, 2, 1'b0, 4, "R4");
    idle(2);

    // R8 truncation: mid-burst and at the last pair
    burst(10'h1F5, 3, 1'b0, 3, "R8");
    burst(10'h09A, 2, 1'b1, 4, "R8");
    idle(1);
    burst(10'h222, 2, 1'b0, 3, "R8");
    burst(10'h330, 3, 1'b1, 8, "R8");
    idle(3);

    wait (exp_q.size() == 0);
    @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule